// File: doc/BRIEF.md
# Idle-Counting Clock Gate Controller

This block produces clock enables for three gated regions next to a shared memory level: the shared control logic, a row of tag banks, and a SIMD/floating-point unit. The enables feed clock gating cells outside the block. The block does not contain those cells, or the logic they clock.

The control enable drops after a run of consecutive cycles with no access. The idle counter stops at its limit and does not wrap. When an access arrives while the control clock is off, the enable returns in the same cycle. The ready output then stays low for a fixed wake-up penalty, and the requester holds its request until ready rises.

Each tag bank enable is high only while an access addresses that bank. The SIMD/FP enable follows a decoded SIMD or floating-point instruction, and only while the unit is powered. A separate configuration bit turns gating off for the banks, and another for the SIMD/FP unit.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset the idle count is zero and no wake-up is pending, so `ctrl_clk_en` is 1 and `acc_ready` equals `acc_req` from the first cycle.
- R2: With `acc_req` low, `ctrl_clk_en` stays 1 for exactly IDLE_LIMIT consecutive cycles and is 0 from the next cycle on. It remains 0 for as long as the idle run lasts, with no wrap of the count.
- R3: Any cycle with `acc_req` high clears the idle count, so a new full window of IDLE_LIMIT idle cycles is needed before the control clock turns off.
- R4: An access that arrives while the control clock is off raises `ctrl_clk_en` in that same cycle. `acc_ready` stays 0 for exactly WAKE_CYCLES cycles, counting that cycle, and rises in the next cycle while the request is held.
- R5: An access in the last idle cycle before the clock would turn off keeps the clock on and is ready at once, with no wake-up penalty.
- R6: With bank gating active, `bank_clk_en` is one-hot at bit `acc_bank` (a binary bank index) while `acc_req` is 1, and is all zero while `acc_req` is 0.
- R7: With `cfg_bank_gate_off` = 1, every bit of `bank_clk_en` is 1, whatever the access inputs are.
- R8: While `simd_pwr_up` = 1 and gating is active, `simd_clk_en` equals `simd_insn`.
- R9: While `simd_pwr_up` = 1 and `cfg_simd_gate_off` = 1, `simd_clk_en` is 1.
- R10: While `simd_pwr_up` = 0, `simd_clk_en` is 0, whatever the gate-off bit and the instruction input are.
- R11: `acc_ready` is never 1 without `acc_req`. While the control clock is on and no wake-up is pending, `acc_ready` equals `acc_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bank_gate_off | input | 1 | 1 keeps all tag bank clocks on |
| cfg_simd_gate_off | input | 1 | 1 keeps the SIMD/FP clock on while the unit is powered |
| simd_pwr_up | input | 1 | SIMD/FP unit is powered |
| simd_insn | input | 1 | A SIMD or floating-point instruction is in the pipeline |
| acc_req | input | 1 | Access request to the shared control logic |
| acc_bank | input | $clog2(NUM_BANKS) | Binary index of the tag bank the access targets |
| acc_ready | output | 1 | The access is serviced this cycle |
| ctrl_clk_en | output | 1 | Clock enable for the shared control logic |
| bank_clk_en | output | NUM_BANKS | Clock enable for each tag bank |
| simd_clk_en | output | 1 | Clock enable for the SIMD/FP unit |

## Verification
The bench builds the block with IDLE_LIMIT = 16, WAKE_CYCLES = 4 and NUM_BANKS = 4. The short idle window makes the exact turn-off cycle reachable in a few dozen cycles. It also allows an idle run of more than twice the limit, which shows that the 5-bit count stops at the limit instead of wrapping and turning the clock back on. Four banks exercise every value of the two-bit bank index. A penalty of four cycles separates an off-by-one in the stall from the correct count.

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
  parameter int IDLE_LIMIT  = 256,
  parameter int WAKE_CYCLES = 4,
  parameter int NUM_BANKS   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_bank_gate_off,
  input  logic                         cfg_simd_gate_off,
  input  logic                         simd_pwr_up,
  input  logic                         simd_insn,
  input  logic                         acc_req,
  input  logic [$clog2(NUM_BANKS)-1:0] acc_bank,
  output logic                         acc_ready,
  output logic                         ctrl_clk_en,
  output logic [NUM_BANKS-1:0]         bank_clk_en,
  output logic                         simd_clk_en
);

  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam int BW = $clog2(NUM_BANKS);

  logic [CW-1:0] idle_cnt;
  logic [WW-1:0] wake_cnt;
  logic          asleep;

  assign asleep = (idle_cnt == CW'(IDLE_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      wake_cnt <= '0;
    end else begin
      if (acc_req)      idle_cnt <= '0;
      else if (!asleep) idle_cnt <= idle_cnt + 1'b1;

      if (acc_req && asleep) wake_cnt <= WW'(WAKE_CYCLES - 1);
      else if (wake_cnt != '0) wake_cnt <= wake_cnt - 1'b1;
    end
  end

  assign ctrl_clk_en = !asleep || acc_req;
  assign acc_ready   = acc_req && !asleep && (wake_cnt == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_clk_en[b] = cfg_bank_gate_off || (acc_req && (acc_bank == BW'(b)));
  end

  assign simd_clk_en = simd_pwr_up && (cfg_simd_gate_off || simd_insn);

endmodule

module clk_gate_ctrl_chk #(
  parameter int IDLE_LIMIT  = 256,
  parameter int WAKE_CYCLES = 4,
  parameter int NUM_BANKS   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_bank_gate_off,
  input logic                         cfg_simd_gate_off,
  input logic                         simd_pwr_up,
  input logic                         simd_insn,
  input logic                         acc_req,
  input logic [$clog2(NUM_BANKS)-1:0] acc_bank,
  input logic                         acc_ready,
  input logic                         ctrl_clk_en,
  input logic [NUM_BANKS-1:0]         bank_clk_en,
  input logic                         simd_clk_en
);

  int unsigned idle_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                   idle_seen <= 0;
    else if (acc_req)             idle_seen <= 0;
    else if (idle_seen < IDLE_LIMIT) idle_seen <= idle_seen + 1;
  end

  assert_off_after_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_req && idle_seen >= IDLE_LIMIT) |-> !ctrl_clk_en);

  assert_on_within_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_seen < IDLE_LIMIT) |-> ctrl_clk_en);

  assert_wake_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> ctrl_clk_en);

  assert_wake_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !$past(ctrl_clk_en)) |-> !acc_ready);

  assert_bank_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bank_gate_off |-> ($onehot0(bank_clk_en) && (acc_req || bank_clk_en == '0)));

  assert_bank_all_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bank_gate_off |-> (&bank_clk_en));

  assert_simd_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (simd_pwr_up && !cfg_simd_gate_off) |-> (simd_clk_en == simd_insn));

  assert_simd_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (simd_pwr_up && cfg_simd_gate_off) |-> simd_clk_en);

  assert_simd_unpowered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !simd_pwr_up |-> !simd_clk_en);

  assert_ready_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> acc_req);

endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk #(
  .IDLE_LIMIT(IDLE_LIMIT), .WAKE_CYCLES(WAKE_CYCLES), .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_bank_gate_off(cfg_bank_gate_off), .cfg_simd_gate_off(cfg_simd_gate_off),
  .simd_pwr_up(simd_pwr_up), .simd_insn(simd_insn),
  .acc_req(acc_req), .acc_bank(acc_bank), .acc_ready(acc_ready),
  .ctrl_clk_en(ctrl_clk_en), .bank_clk_en(bank_clk_en), .simd_clk_en(simd_clk_en)
);

// File: tb/clk_gate_ctrl_tb.sv
`timescale 1ns/1ps
module clk_gate_ctrl_tb;
  localparam int IDLE_LIMIT  = 16;
  localparam int WAKE_CYCLES = 4;
  localparam int NUM_BANKS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bank_gate_off = 1'b0, cfg_simd_gate_off = 1'b0;
  logic simd_pwr_up = 1'b0, simd_insn = 1'b0, acc_req = 1'b0;
  logic [1:0] acc_bank = '0;
  logic acc_ready, ctrl_clk_en, simd_clk_en;
  logic [NUM_BANKS-1:0] bank_clk_en;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_gate_ctrl #(.IDLE_LIMIT(IDLE_LIMIT), .WAKE_CYCLES(WAKE_CYCLES), .NUM_BANKS(NUM_BANKS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_bank_gate_off(cfg_bank_gate_off), .cfg_simd_gate_off(cfg_simd_gate_off),
    .simd_pwr_up(simd_pwr_up), .simd_insn(simd_insn),
    .acc_req(acc_req), .acc_bank(acc_bank), .acc_ready(acc_ready),
    .ctrl_clk_en(ctrl_clk_en), .bank_clk_en(bank_clk_en), .simd_clk_en(simd_clk_en)
  );

  // {bank_off, simd_off, pwr, insn, req, bank[1:0], exp_banks[3:0], exp_simd}
  localparam logic [11:0] VEC [0:11] = '{
    12'b0_0_1_1_1_00_0001_1,
    12'b0_0_1_0_1_01_0010_0,
    12'b0_0_1_1_1_10_0100_1,
    12'b0_0_1_0_1_11_1000_0,
    12'b0_0_1_1_0_10_0000_1,
    12'b1_0_1_0_1_01_1111_0,
    12'b1_0_1_0_0_00_1111_0,
    12'b0_1_1_0_1_00_0001_1,
    12'b0_1_0_1_1_11_1000_0,
    12'b0_0_0_1_1_10_0100_0,
    12'b1_1_0_0_0_00_1111_0,
    12'b0_0_1_0_0_00_0000_0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // advance to the next cycle; inputs are applied 1 ns after the edge, outputs sampled 1 ns later
  task automatic cyc(input logic req);
    @(posedge clk);
    #1 acc_req = req;
    #1;
  endtask

  task automatic idle_run(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 ctrl_clk_en after reset", ctrl_clk_en, 1);
    cyc(1'b1);
    chk("R1 ready follows req after reset", acc_ready, 1);

    // table walk: R6 R7 R8 R9 R10 R11
    for (int v = 0; v < 12; v++) begin
      @(posedge clk);
      #1;
      {cfg_bank_gate_off, cfg_simd_gate_off, simd_pwr_up, simd_insn, acc_req, acc_bank} = VEC[v][11:5];
      #1;
      chk(VEC[v][10] ? "R9/R10 simd_clk_en" : "R8/R10 simd_clk_en", simd_clk_en, VEC[v][0]);
      chk(VEC[v][11] ? "R7 bank_clk_en" : "R6 bank_clk_en", bank_clk_en, VEC[v][4:1]);
      chk("R11 ready equals req", acc_ready, VEC[v][7]);
    end
    cfg_bank_gate_off = 1'b0; cfg_simd_gate_off = 1'b0;

    // R2: exact turn-off point and saturation
    cyc(1'b1);
    idle_run(IDLE_LIMIT);
    chk("R2 on in last idle cycle of window", ctrl_clk_en, 1);
    cyc(1'b0);
    chk("R2 off after window", ctrl_clk_en, 0);
    idle_run(2 * IDLE_LIMIT + 3);
    chk("R2 stays off, no wrap", ctrl_clk_en, 0);
    chk("R6 no bank enable while idle", bank_clk_en, 0);

    // R4: wake-up penalty
    acc_bank = 2'd2;
    cyc(1'b1);
    chk("R4 enable in wake cycle", ctrl_clk_en, 1);
    chk("R4 stall cycle 0", acc_ready, 0);
    chk("R6 bank 2 during wake", bank_clk_en, 4'b0100);
    for (int s = 1; s < WAKE_CYCLES; s++) begin
      cyc(1'b1);
      chk("R4 stall continues", acc_ready, 0);
    end
    cyc(1'b1);
    chk("R4 ready after penalty", acc_ready, 1);

    // R3: access restarts window
    idle_run(10);
    cyc(1'b1);
    chk("R3 ready mid window", acc_ready, 1);
    idle_run(IDLE_LIMIT);
    chk("R3 still on after restart window", ctrl_clk_en, 1);
    cyc(1'b0);
    chk("R3 off after full new window", ctrl_clk_en, 0);

    // R5: access in last idle cycle has no penalty
    cyc(1'b1);
    idle_run(WAKE_CYCLES + 1);
    cyc(1'b1);
    chk("R11 ready with clock on", acc_ready, 1);
    idle_run(IDLE_LIMIT - 1);
    cyc(1'b1);
    chk("R5 enable at boundary", ctrl_clk_en, 1);
    chk("R5 no penalty at boundary", acc_ready, 1);
    cyc(1'b1);
    chk("R5 ready next cycle", acc_ready, 1);
    cyc(1'b0);
    chk("R11 no ready without req", acc_ready, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule